// File: doc/BRIEF.md
# Dual audio baud-rate clock generator

This block derives two audio bit clocks from a set of four master clock sources. Generator A is meant for rates in the 44.1 kHz family and generator B for the 48 kHz family. Each generator has its own source selection and its own divide setting. The block also has a group of clock-out pins, and every pin carries the output of one generator, chosen by a single control bit. The master clocks (A, B, C and an internal clock I) arrive as one-cycle enable ticks in the system clock domain. The generator outputs are registered levels in that same domain.

Each generator divides in two stages. The first stage is a prescaler that divides by a power of two taken from a short code. The second stage is an 8-bit counter. The output is high for the first half of every period. A new divide value is held in a shadow register until the current period ends, so a reprogram never produces a truncated period. A source code with no source assigned to it forces the generator low.

Configuration goes through a write-only port made of an enable, a 2-bit address and a 32-bit data word.

Top module: `audio_brg_top`

## Requirements
- R1: While reset is high, all outputs are low. After reset, both divide registers hold 2, which gives a divide by 6. Both source fields select master clock A, and the clock-out select picks generator A.
- R2: A divide register is 10 bits wide. Bits [9:8] hold a prescale code c, which divides by P = 2<<(2c), so codes 0 to 3 divide by 2, 8, 32 and 128. Bits [7:0] hold N. One output period lasts T = P*(N+1) ticks of the selected source.
- R3: In every period the generator output is high for the first T/2 source ticks and low for the remaining T/2.
- R4: The source code for generator A sits in control bits [22:20], and the code for generator B sits in bits [18:16]. Code 0 selects master clock A, 1 selects B, 2 selects I and 4 selects C.
- R5: Source codes 3, 5, 6 and 7 hold the output of that generator low for as long as they are selected.
- R6: A newly written divide value takes effect at the next period boundary. The period running at the time of the write completes with the old value.
- R7: Control bit 31 chooses the source of the clock-out pins. A value of 0 selects generator A and 1 selects generator B. The clock-out pins follow the chosen generator output with one cycle of delay.
- R8: All clock-out pins carry the same value in every cycle.
- R9: A write to the control register stores only bits 31, 22:20 and 18:16. All other data bits are ignored.
- R10: Register addresses are: 0 for control, 1 for the generator A divide value, 2 for the generator B divide value. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_a_tick | input | 1 | Enable tick of master clock A |
| mclk_b_tick | input | 1 | Enable tick of master clock B |
| mclk_c_tick | input | 1 | Enable tick of master clock C |
| mclk_i_tick | input | 1 | Enable tick of internal master clock I |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| brg_a_clk | output | 1 | Generator A divided clock |
| brg_b_clk | output | 1 | Generator B divided clock |
| clk_out | output | NUM_OUT | Shared clock-out pins |

## Verification
A register write lands on the clock edge that samples it, and a new source code acts on the following cycle. A new divide value waits for the next period boundary. Each generator output is registered, so it trails the internal divider position by one cycle, and the clock-out pins add one more register stage. The bench therefore does not sample after a fixed delay. It timestamps rising and falling edges against a cycle counter and compares the high and low widths, which are T/2 times the tick spacing. After a divide or source change it discards the first measured period, except in the deferral test, where that first period is the result under test. The one-cycle delay of the clock-out pins is checked by comparing each pin with the generator value sampled one cycle earlier.

// File: rtl/audio_brg_pkg.sv
package audio_brg_pkg;

  localparam int SRC_W     = 3;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 32;
  localparam int OSEL_BIT  = 31;
  localparam int SRCA_LSB  = 20;
  localparam int SRCB_LSB  = 16;

  // source codes; the gaps (3,5,6,7) are unused and gate the output
  localparam logic [SRC_W-1:0] SRC_CODE_A = 3'd0;
  localparam logic [SRC_W-1:0] SRC_CODE_B = 3'd1;
  localparam logic [SRC_W-1:0] SRC_CODE_I = 3'd2;
  localparam logic [SRC_W-1:0] SRC_CODE_C = 3'd4;

  // position of each master tick in the tick vector
  localparam int TICK_A = 0;
  localparam int TICK_B = 1;
  localparam int TICK_C = 2;
  localparam int TICK_I = 3;
  localparam int NUM_SRC = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_DIV_A = 2'd1,
    REG_DIV_B = 2'd2,
    REG_SPARE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             out_sel_b;
    logic [SRC_W-1:0] src_a;
    logic [SRC_W-1:0] src_b;
  } ctrl_t;

endpackage

// File: rtl/brg_regs.sv
module brg_regs
  import audio_brg_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_a_o,
  output logic [DIV_W-1:0]  div_b_o
);

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_a_q;
  logic [DIV_W-1:0] div_b_q;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data[30:23], wr_data[19], wr_data[15:DIV_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      div_a_q <= DIV_W'(DIV_RESET);
      div_b_q <= DIV_W'(DIV_RESET);
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_CTRL: begin
          ctrl_q.out_sel_b <= wr_data[OSEL_BIT];
          ctrl_q.src_a     <= wr_data[SRCA_LSB +: SRC_W];
          ctrl_q.src_b     <= wr_data[SRCB_LSB +: SRC_W];
        end
        REG_DIV_A: div_a_q <= wr_data[DIV_W-1:0];
        REG_DIV_B: div_b_q <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign div_a_o = div_a_q;
  assign div_b_o = div_b_q;

  // R10: the spare address leaves every register untouched
  a_r10_spare_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_SPARE) |=>
      ($stable(ctrl_q) && $stable(div_a_q) && $stable(div_b_q)));

endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import audio_brg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PS_W      = 2,
  parameter int DIV_RESET = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_ticks,
  input  logic [SRC_W-1:0]      src_sel,
  input  logic [CNT_W+PS_W-1:0] div_cfg,
  output logic                  gen_clk_o
);

  localparam int DIV_W = CNT_W + PS_W;
  // largest prescale is 2<<(2*(2^PS_W-1)); its count needs this many bits
  localparam int PRE_W = 2 * ((1 << PS_W) - 1) + 1;

  logic             src_ok;
  logic             src_tick;
  logic [DIV_W-1:0] act_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gen_q;

  logic [PS_W-1:0]  ps_code;
  logic [CNT_W-1:0] n_val;
  logic [PRE_W-1:0] pre_last;
  logic [PRE_W-1:0] pre_half;
  logic [CNT_W:0]   n_plus;
  logic [CNT_W-1:0] cnt_half;
  logic             n_odd;
  logic             pre_end;
  logic             cnt_end;
  logic             wrap;
  logic             reload;
  logic             in_high;

  // non-sequential source decode
  always_comb begin
    src_ok   = 1'b1;
    src_tick = 1'b0;
    case (src_sel)
      SRC_CODE_A: src_tick = src_ticks[TICK_A];
      SRC_CODE_B: src_tick = src_ticks[TICK_B];
      SRC_CODE_I: src_tick = src_ticks[TICK_I];
      SRC_CODE_C: src_tick = src_ticks[TICK_C];
      default:    src_ok   = 1'b0;
    endcase
  end

  assign ps_code  = act_q[DIV_W-1:CNT_W];
  assign n_val    = act_q[CNT_W-1:0];
  // prescale P = 2^(2c+1): last count is 2c+1 ones, half is 2^(2c)
  assign pre_last = ~({PRE_W{1'b1}} << {ps_code, 1'b1});
  assign pre_half = PRE_W'(1) << {ps_code, 1'b0};

  assign n_plus   = {1'b0, n_val} + (CNT_W+1)'(1);
  assign cnt_half = n_plus[CNT_W:1];
  assign n_odd    = n_plus[0];

  assign pre_end  = (pre_q == pre_last);
  assign cnt_end  = (cnt_q == n_val);
  assign wrap     = src_ok && src_tick && pre_end && cnt_end;
  assign reload   = !src_ok || wrap;

  // first half of P*(N+1): whole counter steps, plus half a step when N+1 is odd
  assign in_high  = (cnt_q < cnt_half) ||
                    (n_odd && (cnt_q == cnt_half) && (pre_q < pre_half));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= DIV_W'(DIV_RESET);
      gen_q <= 1'b0;
    end else if (!src_ok) begin
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= div_cfg;
      gen_q <= 1'b0;
    end else begin
      if (src_tick) begin
        if (pre_end) begin
          pre_q <= '0;
          if (cnt_end) begin
            cnt_q <= '0;
            act_q <= div_cfg;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
      gen_q <= in_high;
    end
  end

  assign gen_clk_o = gen_q;

  // R2: prescale stage never passes its last count
  a_r2_pre_range: assert property (@(posedge clk) disable iff (rst)
    pre_q <= pre_last);

  // R2: counter stage never passes N
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= n_val);

  // R5: an unused source code drives the output low
  a_r5_gated_low: assert property (@(posedge clk) disable iff (rst)
    !src_ok |=> !gen_clk_o);

  // R6: the active divide value only changes at a period boundary
  a_r6_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(act_q));

endmodule

// File: rtl/brg_clkout.sv
module brg_clkout #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_b,
  input  logic               gen_a,
  input  logic               gen_b,
  output logic [NUM_OUT-1:0] clk_out_o
);

  logic pick;
  assign pick = sel_b ? gen_b : gen_a;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b0;
      else     pin_q <= pick;
    end
    assign clk_out_o[g] = pin_q;
  end

  // R7: pins follow the chosen generator one cycle later
  a_r7_follow_sel: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_out_o[0] == $past(sel_b ? gen_b : gen_a)));

  // R8: every pin carries the same value
  a_r8_pins_equal: assert property (@(posedge clk) disable iff (rst)
    ($countones(clk_out_o) == 0) || ($countones(clk_out_o) == NUM_OUT));

endmodule

// File: rtl/audio_brg_top.sv
module audio_brg_top
  import audio_brg_pkg::*;
#(
  parameter int NUM_OUT   = 4,
  parameter int CNT_W     = 8,
  parameter int PS_W      = 2,
  parameter int DIV_RESET = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mclk_a_tick,
  input  logic               mclk_b_tick,
  input  logic               mclk_c_tick,
  input  logic               mclk_i_tick,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               brg_a_clk,
  output logic               brg_b_clk,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int DIV_W   = CNT_W + PS_W;
  localparam int NUM_GEN = 2;

  ctrl_t                ctrl;
  logic [DIV_W-1:0]     div_a;
  logic [DIV_W-1:0]     div_b;
  logic [NUM_SRC-1:0]   ticks;
  logic [SRC_W-1:0]     gen_src [NUM_GEN];
  logic [DIV_W-1:0]     gen_div [NUM_GEN];
  logic [NUM_GEN-1:0]   gen_clk;

  always_comb begin
    ticks         = '0;
    ticks[TICK_A] = mclk_a_tick;
    ticks[TICK_B] = mclk_b_tick;
    ticks[TICK_C] = mclk_c_tick;
    ticks[TICK_I] = mclk_i_tick;
  end

  brg_regs #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .ctrl_o  (ctrl),
    .div_a_o (div_a),
    .div_b_o (div_b)
  );

  assign gen_src[0] = ctrl.src_a;
  assign gen_src[1] = ctrl.src_b;
  assign gen_div[0] = div_a;
  assign gen_div[1] = div_b;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    brg_divider #(
      .CNT_W     (CNT_W),
      .PS_W      (PS_W),
      .DIV_RESET (DIV_RESET)
    ) div_i (
      .clk       (clk),
      .rst       (rst),
      .src_ticks (ticks),
      .src_sel   (gen_src[g]),
      .div_cfg   (gen_div[g]),
      .gen_clk_o (gen_clk[g])
    );
  end

  brg_clkout #(
    .NUM_OUT (NUM_OUT)
  ) clkout_i (
    .clk       (clk),
    .rst       (rst),
    .sel_b     (ctrl.out_sel_b),
    .gen_a     (gen_clk[0]),
    .gen_b     (gen_clk[1]),
    .clk_out_o (clk_out)
  );

  assign brg_a_clk = gen_clk[0];
  assign brg_b_clk = gen_clk[1];

endmodule

// File: tb/audio_brg_top_tb_top.sv
module audio_brg_top_tb_top;

  localparam int NUM_OUT = 4;
  localparam int TMO     = 4000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ta = 1'b0, tb = 1'b0, tc = 1'b0, ti = 1'b0;
  logic               wr_en = 1'b0;
  logic [1:0]         addr = '0;
  logic [31:0]        wdata = '0;
  logic               gen_a, gen_b;
  logic [NUM_OUT-1:0] cko;

  int ka = 0, kb = 0, kc = 0, ki = 0;
  int ca = 0, cb = 0, cc = 0, ci = 0;
  int cyc = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  audio_brg_top #(.NUM_OUT(NUM_OUT)) dut_i (
    .clk(clk), .rst(rst),
    .mclk_a_tick(ta), .mclk_b_tick(tb), .mclk_c_tick(tc), .mclk_i_tick(ti),
    .cfg_wr_en(wr_en), .cfg_addr(addr), .cfg_wdata(wdata),
    .brg_a_clk(gen_a), .brg_b_clk(gen_b), .clk_out(cko)
  );

  always @(posedge clk) cyc = cyc + 1;

  // master clock ticks: one cycle high every k cycles, k = 0 means silent
  always @(negedge clk) begin
    ta = (ka != 0) && (ca == 0); ca = (ka == 0) ? 0 : (ca + 1) % ka;
    tb = (kb != 0) && (cb == 0); cb = (kb == 0) ? 0 : (cb + 1) % kb;
    tc = (kc != 0) && (cc == 0); cc = (kc == 0) ? 0 : (cc + 1) % kc;
    ti = (ki != 0) && (ci == 0); ci = (ki == 0) ? 0 : (ci + 1) % ki;
  end

  function automatic logic sig(input int idx);
    case (idx)
      0:       return gen_a;
      1:       return gen_b;
      default: return cko[0];
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input int idx, input logic v, output int t);
    t = -1;
    for (int n = 0; n < TMO; n++) begin
      @(negedge clk);
      if (sig(idx) == v) begin
        t = cyc;
        break;
      end
    end
    if (t < 0) check("edge timeout", 0, 1);
  endtask

  task automatic measure(input int idx, output int hi, output int lo);
    int t0, t1, t2, tx;
    wait_level(idx, 1'b0, tx);
    wait_level(idx, 1'b1, t0);
    wait_level(idx, 1'b0, t1);
    wait_level(idx, 1'b1, t2);
    hi = t1 - t0;
    lo = t2 - t1;
  endtask

  // first period after a change may still run on the old setting
  task automatic settled(input int idx, output int hi, output int lo);
    measure(idx, hi, lo);
    measure(idx, hi, lo);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check("R1 reset outputs low", {gen_a, gen_b, |cko}, 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_default;
    int hi, lo;
    ka = 2;
    settled(0, hi, lo);
    check("R1 default A high", hi, 6);
    check("R3 default A low", lo, 6);
    settled(1, hi, lo);
    check("R1 default B high", hi, 6);
  endtask

  task automatic t_prescale;
    int hi, lo;
    ka = 1;
    wr(2'd1, 32'h101);
    settled(0, hi, lo);
    check("R2 P8 N1 high", hi, 8);
    check("R3 P8 N1 low", lo, 8);
    wr(2'd1, 32'h200);
    settled(0, hi, lo);
    check("R2 P32 N0 high", hi, 16);
    wr(2'd1, 32'h301);
    settled(0, hi, lo);
    check("R2 P128 N1 high", hi, 128);
    check("R3 P128 N1 low", lo, 128);
    wr(2'd1, 32'h004);
    settled(0, hi, lo);
    check("R3 odd N+1 high", hi, 5);
    check("R3 odd N+1 low", lo, 5);
  endtask

  task automatic t_sources;
    int hi, lo;
    ka = 1; kb = 4; kc = 3; ki = 5;
    wr(2'd1, 32'h002);
    wr(2'd2, 32'h002);
    wr(2'd0, 32'd4 << 20);
    settled(0, hi, lo);
    check("R4 A from C high", hi, 9);
    wr(2'd0, 32'd2 << 20);
    settled(0, hi, lo);
    check("R4 A from I high", hi, 15);
    wr(2'd0, 32'd1 << 20);
    settled(0, hi, lo);
    check("R4 A from B high", hi, 12);
    wr(2'd0, 32'd4 << 16);
    settled(1, hi, lo);
    check("R4 B from C high", hi, 9);
  endtask

  task automatic t_gate;
    int na = 0, nb = 0;
    wr(2'd0, (32'd3 << 20) | (32'd7 << 16));
    repeat (3) @(negedge clk);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      na += int'(gen_a);
      nb += int'(gen_b);
    end
    check("R5 A code 3 high samples", na, 0);
    check("R5 B code 7 high samples", nb, 0);
  endtask

  task automatic t_outsel;
    int hi, lo, lag_bad = 0, pin_bad = 0;
    logic prev;
    ka = 1;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h001);
    wr(2'd2, 32'h101);
    settled(2, hi, lo);
    check("R7 clk_out from A high", hi, 2);
    wr(2'd0, 32'h8000_0000);
    settled(2, hi, lo);
    check("R7 clk_out from B high", hi, 8);
    @(negedge clk);
    prev = gen_b;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (cko[0] != prev) lag_bad++;
      if (cko != {NUM_OUT{cko[0]}}) pin_bad++;
      prev = gen_b;
    end
    check("R7 one-cycle lag mismatches", lag_bad, 0);
    check("R8 pin mismatches", pin_bad, 0);
  endtask

  task automatic t_mask;
    int hi, lo;
    // bit 31 clear, both source fields 0, every ignored bit set
    wr(2'd0, 32'h7F88_FFFF);
    settled(2, hi, lo);
    check("R9 masked write clk_out from A", hi, 2);
    settled(1, hi, lo);
    check("R9 masked write B source A", hi, 8);
  endtask

  task automatic t_spare;
    int hi, lo;
    wr(2'd3, 32'hFFFF_FFFF);
    settled(2, hi, lo);
    check("R10 spare write clk_out", hi, 2);
    settled(1, hi, lo);
    check("R10 spare write B", hi, 8);
  endtask

  task automatic t_defer;
    int hi, lo, t0, t1, t2, t3, t4, tx;
    ka = 4;
    wr(2'd1, 32'h003);
    settled(0, hi, lo);
    check("R6 old period high", hi, 16);
    wait_level(0, 1'b0, tx);
    wait_level(0, 1'b1, t0);
    wr(2'd1, 32'h007);
    wait_level(0, 1'b0, t1);
    wait_level(0, 1'b1, t2);
    wait_level(0, 1'b0, t3);
    wait_level(0, 1'b1, t4);
    check("R6 running period high", t1 - t0, 16);
    check("R6 running period low", t2 - t1, 16);
    check("R6 next period high", t3 - t2, 32);
    check("R6 next period low", t4 - t3, 32);
  endtask

  initial begin
    t_reset();
    t_default();
    t_prescale();
    t_sources();
    t_gate();
    t_outsel();
    t_mask();
    t_spare();
    t_defer();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule